// File: doc/BRIEF.md
# Polarity-Selective Pulse Qualifier

This block watches one digital input pin and produces a filtered logical level from it. It times only excursions away from a configured resting level. An excursion is confirmed once it has lasted a programmed number of millisecond ticks. Anything shorter is discarded as noise. When the pin goes back to its resting level, the confirmation is dropped on the next clock, with no delay. Because only one side is timed, two instances on the same pin can give different on-delay and off-delay behaviour: one in normal polarity with the on-delay, and one in inverted polarity with the off-delay.

In normal polarity the pin rests low, and a confirmed high excursion drives the filtered output to 1. In inverted polarity the pin rests high, and a confirmed low excursion drives the filtered output to 0, which matches the actual pin level. The filtered level comes from internal registers fed by a synchronizer, not from the pin. A separate output passes the raw pin level through unchanged. Time is counted in pulses of an external one-clock-wide millisecond tick.

Top module: `pulse_qualifier`

## Requirements
- R1: With `invert_sel`=0, `filt_out` becomes 1 only after the synchronized input has been high while `delay_ms` tick pulses arrived. It rises on the clock edge after the edge that counted the last of those ticks.
- R2: An excursion that returns to rest before `delay_ms` ticks have been counted leaves `filt_out` at its resting value throughout.
- R3: With `invert_sel`=1, the pin rests high and only low excursions are timed. `filt_out` rests at 1 and reads 0 while a low excursion is confirmed.
- R4: When the synchronized input returns to the resting level, the confirmation clears on the next clock edge. `filt_out` then returns to rest 3 rising edges after the pin changes, whatever the delay setting.
- R5: `raw_out` equals `pin_in` at all times, with no register on the path.
- R6: `pin_in` passes through a chain of `SYNC_STAGES` flops (default 2) before it is used for timing. The stages are loaded with the resting level during reset.
- R7: The tick counter saturates at `delay_ms` and clears whenever the synchronized input is at rest. An excursion that lasts far longer than the delay stays confirmed until it ends.
- R8: With `delay_ms`=0, `filt_out` follows the synchronized input. It changes 3 rising edges after the pin changes.
- R9: While `rst_n` is low (synchronous, active low), `filt_out` equals `invert_sel`: 0 in normal polarity, 1 in inverted polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| pin_in | input | 1 | Raw asynchronous input pin |
| delay_ms | input | DELAY_W | Qualification length in ticks |
| invert_sel | input | 1 | 0: rests low, times high pulses; 1: rests high, times low pulses |
| filt_out | output | 1 | Filtered logical state |
| raw_out | output | 1 | Unfiltered pin level |

## Verification
The assertions check several things on every cycle. The counter clears at rest and never advances without a tick. It holds once saturated. The confirmation drops on the first cycle the synchronized level is back at rest. A zero delay confirms in the next cycle. Only the bench's scenarios can show the rest. These are the pin-to-output latency through the synchronizer, the rejection of a short pulse over its whole length, and the inverted reading in the opposite polarity. They also include a long excursion staying confirmed and the raw pass-through.

// File: rtl/pq_pkg.sv
package pq_pkg;
   typedef enum logic {
      PQ_REST_LOW  = 1'b0,
      PQ_REST_HIGH = 1'b1
   } pq_rest_e;

   function automatic logic pq_away(input logic lvl, input pq_rest_e rest);
      return lvl ^ logic'(rest);
   endfunction
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rest_lvl,
   input  logic d_in,
   output logic q_out
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= rest_lvl;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= rest_lvl;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[LAST];
endmodule

// File: rtl/pq_timer.sv
module pq_timer #(
   parameter int DELAY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               away,
   input  logic               tick,
   input  logic [DELAY_W-1:0] limit,
   output logic               reached
);
   localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

   logic [DELAY_W-1:0] cnt;
   logic               can_step;

   generate
      if (DELAY_W < 1 || DELAY_W > 32) begin : g_bad_width
         $error("pq_timer: DELAY_W must be 1..32");
      end
   endgenerate

   assign can_step = tick && (cnt < limit);
   assign reached  = (cnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!away)    cnt <= '0;
      else if (can_step) cnt <= cnt + ONE;
   end

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !away |=> (cnt == '0));  // R7
   AST_CNT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (away && !tick) |=> (cnt == $past(cnt) || cnt == '0));  // R1
   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (away && cnt >= limit) |=> (cnt == $past(cnt) || cnt == '0));  // R7
endmodule

// File: rtl/pq_state.sv
module pq_state (
   input  logic clk,
   input  logic rst_n,
   input  logic away,
   input  logic reached,
   output logic qual
);
   always_ff @(posedge clk) begin
      if (!rst_n) qual <= 1'b0;
      else        qual <= away & reached;
   end
endmodule

// File: rtl/pulse_qualifier.sv
module pulse_qualifier #(
   parameter int DELAY_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_ms,
   input  logic               pin_in,
   input  logic [DELAY_W-1:0] delay_ms,
   input  logic               invert_sel,
   output logic               filt_out,
   output logic               raw_out
);
   import pq_pkg::*;

   pq_rest_e rest;
   logic     sync_lvl;
   logic     away;
   logic     reached;
   logic     qual;

   assign rest = pq_rest_e'(invert_sel);

   pq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rest_lvl(invert_sel),
      .d_in(pin_in), .q_out(sync_lvl)
   );

   assign away = pq_away(sync_lvl, rest);

   pq_timer #(.DELAY_W(DELAY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .away(away), .tick(tick_ms),
      .limit(delay_ms), .reached(reached)
   );

   pq_state u_state (
      .clk(clk), .rst_n(rst_n), .away(away),
      .reached(reached), .qual(qual)
   );

   assign filt_out = qual ^ invert_sel;
   assign raw_out  = pin_in;

   AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_lvl == invert_sel) |=> !qual);  // R4
   AST_ZERO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_ms == '0 && sync_lvl != invert_sel) |=> qual);  // R8
   AST_RISE_NEEDS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> $past(sync_lvl != invert_sel));  // R2
endmodule

// File: tb/pulse_qualifier_tb.sv
module pulse_qualifier_tb;
   localparam int DW   = 16;
   localparam int TDIV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_ms = 1'b0;
   logic          pin_in = 1'b0;
   logic [DW-1:0] delay_ms = '0;
   logic          invert_sel = 1'b0;
   logic          filt_out, raw_out;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req  = "R9";
   int    rise_cnt = 0;
   bit    done     = 0;

   logic exp_q[$];

   always #5 clk = ~clk;

   pulse_qualifier #(.DELAY_W(DW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pin_in(pin_in),
      .delay_ms(delay_ms), .invert_sel(invert_sel),
      .filt_out(filt_out), .raw_out(raw_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // tick generator, driven on falling edges
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
      tick_ms <= (tdiv == 0);
   end

   // expectation model: two sync stages, tick counting while away from rest
   logic m_s1 = 0, m_s2 = 0, m_q = 0;
   int   m_cnt = 0;
   always @(posedge clk) begin
      logic awy, nq;
      if (!rst_n) begin
         m_s1 = invert_sel; m_s2 = invert_sel; m_cnt = 0; m_q = 0;
      end else begin
         awy = m_s2 ^ invert_sel;
         nq  = awy && (m_cnt >= int'(delay_ms));
         if (!awy) m_cnt = 0;
         else if (tick_ms && m_cnt < int'(delay_ms)) m_cnt++;
         m_q  = nq;
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
      exp_q.push_back(m_q ^ invert_sel);
   end

   // monitor: pops one expected value per cycle
   always @(posedge clk) begin
      logic prev;
      prev = filt_out;
      #2;
      if (exp_q.size() > 0) chk({"scoreboard ", cur_req}, filt_out, exp_q.pop_front());
      if (prev !== filt_out && filt_out !== invert_sel) rise_cnt++;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic inv);
      @(negedge clk);
      rst_n = 0; invert_sel = inv; pin_in = inv;
      wait_cyc(3);
      cur_req = "R9";
      chk("R9 reset level", filt_out, inv);
      rst_n = 1;
      wait_cyc(2);
   endtask

   initial begin
      #1_000_000;
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      do_reset(1'b0);

      // R5 raw pass-through
      cur_req = "R5";
      pin_in = 1; #1 chk("R5 raw high", raw_out, 1'b1);
      pin_in = 0; #1 chk("R5 raw low", raw_out, 1'b0);
      wait_cyc(5);

      // R8 zero delay latency of 3 edges (R6 synchronizer depth)
      cur_req = "R8"; delay_ms = 0;
      @(negedge clk); pin_in = 1;
      @(posedge clk); @(posedge clk); #2 chk("R6 still low after 2 edges", filt_out, 1'b0);
      @(posedge clk); #2 chk("R8 follows after 3 edges", filt_out, 1'b1);
      @(negedge clk); pin_in = 0;
      @(posedge clk); @(posedge clk); #2 chk("R8 holds after 2 edges", filt_out, 1'b1);
      @(posedge clk); #2 chk("R8 drops after 3 edges", filt_out, 1'b0);
      wait_cyc(5);

      // R2 short pulse rejected
      cur_req = "R2"; delay_ms = 5;
      wait_cyc(3);
      rise_cnt = 0;
      @(negedge clk); pin_in = 1;
      wait_cyc(25);
      pin_in = 0;
      wait_cyc(10);
      chk("R2 no activity on short pulse", logic'(rise_cnt != 0), 1'b0);

      // R1 long pulse qualifies, R7 stays qualified, R4 immediate clear
      cur_req = "R1";
      @(negedge clk); pin_in = 1;
      wait_cyc(90);
      chk("R1 qualified after long high", filt_out, 1'b1);
      cur_req = "R7";
      wait_cyc(300);
      chk("R7 still qualified", filt_out, 1'b1);
      cur_req = "R4";
      @(negedge clk); pin_in = 0;
      @(posedge clk); @(posedge clk); #2 chk("R4 held 2 edges", filt_out, 1'b1);
      @(posedge clk); #2 chk("R4 cleared at 3rd edge", filt_out, 1'b0);
      wait_cyc(10);

      // R3 inverted polarity
      do_reset(1'b1);
      cur_req = "R3"; delay_ms = 4;
      chk("R3 rests high", filt_out, 1'b1);
      rise_cnt = 0;
      @(negedge clk); pin_in = 0;
      wait_cyc(18);
      pin_in = 1;
      wait_cyc(10);
      chk("R3 short low rejected", logic'(rise_cnt != 0), 1'b0);
      @(negedge clk); pin_in = 0;
      wait_cyc(80);
      chk("R3 long low reads 0", filt_out, 1'b0);
      cur_req = "R4";
      @(negedge clk); pin_in = 1;
      wait_cyc(3);
      chk("R4 inverted clears", filt_out, 1'b1);

      // R8 in inverted polarity
      cur_req = "R8"; delay_ms = 0;
      @(negedge clk); pin_in = 0;
      wait_cyc(4);
      chk("R8 inverted follows", filt_out, 1'b0);
      pin_in = 1;
      wait_cyc(6);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule